// File: doc/BRIEF.md
# SDR SDRAM Burst Sequencer

This block sits on the controller side of a 16-bit single-data-rate SDRAM and turns column accesses into command timing. It decodes the burst length and the write-burst behaviour from a programmed mode word, and it takes the read latency (2 or 3 clocks) from a static configuration pin. The latency is chosen to suit the clock rate, because the shorter latency is only good at lower frequencies. Row opening, precharge, refresh and power-up are handled elsewhere. Every request is assumed to target a row that is already open.

A requester presents a read or a write with a bank and a column. The sequencer acknowledges it only when the previous data phase has fully ended, and it puts the command on the bus one cycle later. For a read it raises a capture strobe on exactly the cycles when the memory's data is valid. For a write it enables the controller's data drivers for the number of beats the mode word implies. A mode word with reserved contents is flagged and no requests are taken while it is present.

Top module: `sdr_burst_seq`

## Requirements
- R1: After reset the command output is NOP (code 0), both the read strobe `rd_valid` and the write drive enable `dq_oe` are low, and `req_ack` is high when the mode word is legal.
- R2: Mode bits [1:0] give the burst length as 1 << code: code 0 is 1 beat, 1 is 2 beats, 2 is 4 beats and 3 is 8 beats.
- R3: The mode word is reserved when bit 2 is set or when bits [8:7] are not both zero. In that case `mode_err` is high, `req_ack` stays low and only NOP is issued.
- R4: A request accepted at a clock edge (`req_valid` and `req_ack` both high) appears as a single command in the following cycle, with the request's bank and column on `cmd_bank` and `cmd_col`. The command codes are 1 for a read and 2 for a write.
- R5: For a read seen on the bus in cycle c, `rd_valid` is high for exactly burst-length consecutive cycles starting at cycle c+m. Here m is 2 when `lat3` is 0 and 3 when `lat3` is 1, so the strobe lines up with edge n+m for a command registered at edge n.
- R6: With mode bit 9 clear, a write keeps `dq_oe` high for burst-length consecutive cycles, starting in the cycle that carries the write command.
- R7: With mode bit 9 set, every write drives exactly one beat, while reads still use the full burst length.
- R8: `req_ack` stays low from the accept edge until the last data cycle of the current access has ended, and it is high again in the cycle that follows. Every cycle that is not a command cycle carries NOP, and `dq_oe` and `rd_valid` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_word | input | 12 | Programmed mode word (static while requests are in flight) |
| lat3 | input | 1 | Read latency select: 0 = 2 cycles, 1 = 3 cycles |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_bank | input | BANK_W | Target bank |
| req_col | input | COL_W | Target column |
| req_ack | output | 1 | Request accepted at this edge when req_valid is high |
| mode_err | output | 1 | Mode word holds a reserved value |
| cmd | output | 2 | 0 = NOP, 1 = READ, 2 = WRITE |
| cmd_bank | output | BANK_W | Bank for the current command |
| cmd_col | output | COL_W | Column for the current command |
| dq_oe | output | 1 | Controller drives write data this cycle |
| rd_valid | output | 1 | Read data valid; capture at the end of this cycle |

## Verification
The hardest case to reach is a sequence that exercises every pairing of latency, burst code and write-burst mode, with back-to-back requests that arrive in the very first cycle `req_ack` comes back. Those requests show whether the handover is off by one cycle or whether the bus is ever driven by both sides. The stimulus therefore keeps `req_valid` asserted continuously and draws a fresh random mode, latency, direction and address before each transaction. Directed cases cover the 8-beat read at latency 3, single-beat writes with an 8-beat read setting, and each reserved mode pattern.

// File: rtl/sdr_burst_seq.sv
module sdr_burst_seq #(
  parameter int COL_W  = 10,
  parameter int BANK_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [11:0]       mode_word,
  input  logic              lat3,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [BANK_W-1:0] req_bank,
  input  logic [COL_W-1:0]  req_col,
  output logic              req_ack,
  output logic              mode_err,
  output logic [1:0]        cmd,
  output logic [BANK_W-1:0] cmd_bank,
  output logic [COL_W-1:0]  cmd_col,
  output logic              dq_oe,
  output logic              rd_valid
);
  localparam int CNT_W = 4;
  localparam logic [1:0] CMD_NOP = 2'd0, CMD_RD = 2'd1, CMD_WR = 2'd2;

  logic             busy, is_wr, lat3_q;
  logic [CNT_W-1:0] k, last;
  logic [CNT_W-1:0] bl, wlen, lat;
  logic             accept;

  assign mode_err = mode_word[2] | (|mode_word[8:7]);
  assign bl       = CNT_W'(1) << mode_word[1:0];
  assign wlen     = mode_word[9] ? CNT_W'(1) : bl;
  assign req_ack  = !busy && !mode_err;
  assign accept   = req_valid && req_ack;
  assign lat      = lat3_q ? CNT_W'(3) : CNT_W'(2);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      is_wr    <= 1'b0;
      lat3_q   <= 1'b0;
      k        <= '0;
      last     <= '0;
      cmd_bank <= '0;
      cmd_col  <= '0;
    end else if (accept) begin
      busy     <= 1'b1;
      is_wr    <= req_write;
      lat3_q   <= lat3;
      k        <= CNT_W'(1);
      last     <= req_write ? wlen : (lat3 ? CNT_W'(3) : CNT_W'(2)) + bl;
      cmd_bank <= req_bank;
      cmd_col  <= req_col;
    end else if (busy) begin
      if (k == last) begin
        busy <= 1'b0;
        k    <= '0;
      end else begin
        k <= k + CNT_W'(1);
      end
    end
  end

  assign cmd      = (busy && k == CNT_W'(1)) ? (is_wr ? CMD_WR : CMD_RD) : CMD_NOP;
  assign dq_oe    = busy && is_wr;
  assign rd_valid = busy && !is_wr && (k > lat);

  p_cmd_code_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cmd != 2'd3);
  p_issue_after_ack_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ack) |=> (cmd != CMD_NOP));
  p_rd_lat2_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_RD && !lat3_q) |-> ##2 rd_valid);
  p_rd_lat3_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_RD && lat3_q) |-> ##3 (rd_valid && $past(!rd_valid)));
  p_wr_drive_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_WR) |-> dq_oe);
  p_reserved_block_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mode_err |-> !req_ack);
  p_no_contention_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(dq_oe && rd_valid));
  p_ack_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    req_ack |-> (!dq_oe && !rd_valid && cmd == CMD_NOP));
endmodule

// File: tb/sdr_burst_seq_bench.sv
module sdr_burst_seq_bench;
  localparam int COL_W = 10, BANK_W = 2;

  logic clk = 0, rst_n = 0;
  logic [11:0] mode_word = '0;
  logic lat3 = 0, req_valid = 0, req_write = 0;
  logic [BANK_W-1:0] req_bank = '0;
  logic [COL_W-1:0]  req_col = '0;
  logic req_ack, mode_err, dq_oe, rd_valid;
  logic [1:0] cmd;
  logic [BANK_W-1:0] cmd_bank;
  logic [COL_W-1:0]  cmd_col;

  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  sdr_burst_seq #(.COL_W(COL_W), .BANK_W(BANK_W)) u_sdr_burst_seq (
    .clk, .rst_n, .mode_word, .lat3, .req_valid, .req_write, .req_bank, .req_col,
    .req_ack, .mode_err, .cmd, .cmd_bank, .cmd_col, .dq_oe, .rd_valid);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int f_bl(input logic [11:0] m);
    return 1 << m[1:0];
  endfunction
  function automatic int f_wlen(input logic [11:0] m);
    return m[9] ? 1 : f_bl(m);
  endfunction
  function automatic int f_lat(input logic l3);
    return l3 ? 3 : 2;
  endfunction

  task automatic run_access(input logic wr, input logic [BANK_W-1:0] b,
                            input logic [COL_W-1:0] c, input bit drop_valid);
    int last, lat, n;
    req_write = wr; req_bank = b; req_col = c; req_valid = 1;
    #1;
    chk(req_ack == 1, "R8 idle ack", req_ack, 1);
    @(posedge clk);
    lat  = f_lat(lat3);
    last = wr ? f_wlen(mode_word) : lat + f_bl(mode_word);
    n = 0;
    for (int k = 1; k <= last + 1; k++) begin
      @(negedge clk);
      if (drop_valid) req_valid = 0;
      if (k == 1) begin
        chk(cmd == (wr ? 2'd2 : 2'd1), wr ? "R4 write cmd" : "R4 read cmd", cmd, wr ? 2 : 1);
        chk(cmd_bank == b && cmd_col == c, "R4 address", {cmd_bank, cmd_col}, {b, c});
      end else begin
        chk(cmd == 2'd0, "R8 nop", cmd, 0);
      end
      if (wr) begin
        chk(dq_oe == (k <= last), mode_word[9] ? "R7 single write" : "R6 write beats", dq_oe, k <= last);
        chk(rd_valid == 0, "R8 no strobe on write", rd_valid, 0);
      end else begin
        chk(rd_valid == (k > lat && k <= last), "R5 read strobe", rd_valid, k > lat && k <= last);
        chk(dq_oe == 0, "R8 no drive on read", dq_oe, 0);
        if (rd_valid) n++;
      end
      if (k <= last) chk(req_ack == 0, "R8 ack held", req_ack, 0);
      else           chk(req_ack == 1, "R8 ack returns", req_ack, 1);
    end
    if (!wr) chk(n == f_bl(mode_word), "R2 beat count", n, f_bl(mode_word));
    // back-to-back: valid stays up, next access accepted at the edge ending cycle last+1
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(cmd == 0 && !dq_oe && !rd_valid, "R1 reset outputs", {cmd, dq_oe, rd_valid}, 0);
    rst_n = 1;
    @(negedge clk);
    chk(cmd == 0 && !dq_oe && !rd_valid, "R1 idle outputs", {cmd, dq_oe, rd_valid}, 0);
    chk(req_ack == 1, "R1 ack after reset", req_ack, 1);

    // directed corners
    mode_word = 12'h003; lat3 = 1; run_access(0, 2'd3, 10'h3ff, 1);
    mode_word = 12'h203; lat3 = 0; run_access(1, 2'd1, 10'h012, 1);
    run_access(0, 2'd2, 10'h100, 1);
    for (int code = 0; code < 4; code++) begin
      mode_word = 12'(code); lat3 = 0;
      run_access(0, 2'd0, 10'(code), 1);
      run_access(1, 2'd0, 10'(code), 1);
    end

    // reserved patterns
    for (int p = 0; p < 4; p++) begin
      @(negedge clk);
      case (p)
        0: mode_word = 12'h004;
        1: mode_word = 12'h080;
        2: mode_word = 12'h100;
        default: mode_word = 12'h187;
      endcase
      req_valid = 1; req_write = p[0];
      for (int i = 0; i < 6; i++) begin
        @(negedge clk);
        chk(mode_err == 1, "R3 flag", mode_err, 1);
        chk(req_ack == 0, "R3 no ack", req_ack, 0);
        chk(cmd == 0 && !dq_oe && !rd_valid, "R3 idle bus", {cmd, dq_oe, rd_valid}, 0);
      end
      req_valid = 0;
    end
    mode_word = 12'h002;
    @(negedge clk);
    chk(mode_err == 0, "R3 flag clears", mode_err, 0);

    // random back-to-back
    void'($urandom(32'h5eed));
    for (int t = 0; t < 400; t++) begin
      logic [11:0] m;
      m = 12'($urandom_range(0, 3)) | ($urandom_range(0, 1) ? 12'h200 : 12'h000)
        | ($urandom_range(0, 1) ? 12'h008 : 12'h000);
      mode_word = m;
      lat3 = 1'($urandom_range(0, 1));
      run_access(1'($urandom_range(0, 1)), BANK_W'($urandom), COL_W'($urandom), 0);
    end
    req_valid = 0;
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule